// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache with Not-Recently-Used Replacement

This block is a small data cache that sits between a processor and main memory. It works on 32-bit word addresses: address bit 0 picks one of the two words in a block, bits [3:1] pick one of 8 sets, and bits [31:4] are the 28-bit tag. Each set has two ways. Each way holds a valid flag, a dirty flag, a reference flag, a tag and two data words. Writes are kept in the cache and reach memory only when a dirty block is evicted. A write miss first brings the block into the cache and then writes it.

Replacement uses the reference flags. An access that hits a way sets that way's flag and clears the flag of the other way in the same set. On a miss the cache replaces the way whose flag is 0. If both flags are 0, way 0 is replaced. If the victim is dirty, its two words go to memory first, word 0 then word 1, starting at address {victim tag, index, 0}. The cache then reads the requested block, word 0 then word 1, starting at the request address with bit 0 cleared. It then finishes the access as a hit.

Both sides use valid/ready handshakes.
- Processor side: the processor raises `cpu_valid` and holds the address, direction and write data stable until it sees `cpu_ready` high. A request completes on the clock edge where both are high. `cpu_ready` is produced combinationally from the request. On a hit it is high in the same cycle. On a miss it stays low until the refill has finished.
- Memory side: one word moves on each clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the cache holds `mem_addr`, `mem_write` and `mem_wdata` stable. Memory may hold `mem_ready` low for any number of cycles.

Top module: `nru_cache2w`

## Requirements
- R1: After reset every entry is empty: V, D and R are 0 and the data is zero. `cpu_ready` and `mem_valid` are low, and the first access to any address is a miss.
- R2: The address is split as follows: bit 0 selects the word in the block (0 = word 0), bits [3:1] select the set, and bits [31:4] are compared with the stored tag.
- R3: An access that completes on a way sets that way's R bit and clears the R bit of the other way in the same set. At most one way per set has R=1.
- R4: On a miss the victim is the way with R=0. When both ways have R=0, the victim is way 0. The other way keeps its block.
- R5: A victim with D=1 is written to memory before any refill read. The write-back is two write beats at {victim tag, index, 0} and then {victim tag, index, 1}, carrying word 0 and then word 1.
- R6: A refill is two read beats at {request address bits [31:1], 0} and then {request address bits [31:1], 1}. A clean victim causes no write beats.
- R7: A read hit returns the addressed word with `cpu_ready` high in the same cycle as the request, and it causes no memory beats.
- R8: A write hit changes only the addressed word and sets D=1. The other word of the block keeps its value.
- R9: A write miss allocates the block. After the access completes, the entry holds the written word and is V=1, D=1, R=1, so a later eviction writes the block back.
- R10: `cpu_ready` is high only while `cpu_valid` is high. During a miss it stays low until both refill beats have been accepted.
- R11: A memory beat moves only when `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts or supplies the beat |
| mem_write | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with `mem_ready` |

## Verification
The bench uses one set to run this sequence: a miss, a hit, a conflicting miss, a re-reference, and a third conflicting tag. This tells apart a victim chosen by the reference flags from one chosen by a fixed way or by arrival order. Write misses and write hits are then evicted, and the logged beat sequence is checked for order, addresses and data. This tells apart write-back-then-refill from the reverse order, clean evictions from dirty ones, and a word-wise update from a whole-block update. Each memory beat is stalled for one cycle before it is accepted. This exposes address or direction changes during back-pressure and checks the exact stall length of clean and dirty misses.

// File: rtl/nru_cache_pkg.sv
package nru_cache_pkg;
  localparam int BLK_WORDS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB0,
    ST_WB1,
    ST_RF0,
    ST_RF1
  } cstate_e;
endpackage

// File: rtl/nru_way_bank.sv
module nru_way_bank #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ref_set,
  input  logic              ref_clr,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              fill_we,
  input  logic              fill_sel,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              install,
  input  logic [TAG_W-1:0]  install_tag,
  output logic              valid_o,
  output logic              dirty_o,
  output logic              ref_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] w0_o,
  output logic [DATA_W-1:0] w1_o
);
  logic [SETS-1:0]   val_q, dty_q, ref_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
      ref_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]    <= '0;
        dat_q[s][0] <= '0;
        dat_q[s][1] <= '0;
      end
    end else begin
      if (ref_set)      ref_q[idx] <= 1'b1;
      else if (ref_clr) ref_q[idx] <= 1'b0;
      if (cpu_we) begin
        dat_q[idx][cpu_sel] <= cpu_data;
        dty_q[idx]          <= 1'b1;
      end
      if (fill_we) dat_q[idx][fill_sel] <= fill_data;
      if (install) begin
        val_q[idx] <= 1'b1;
        dty_q[idx] <= 1'b0;
        tag_q[idx] <= install_tag;
      end
    end
  end

  assign valid_o = val_q[idx];
  assign dirty_o = dty_q[idx];
  assign ref_o   = ref_q[idx];
  assign tag_o   = tag_q[idx];
  assign w0_o    = dat_q[idx][0];
  assign w1_o    = dat_q[idx][1];
endmodule

// File: rtl/nru_victim_pick.sv
module nru_victim_pick (
  input  logic [1:0] ref_bits,
  input  logic [1:0] dirty_bits,
  output logic       way,
  output logic       way_dirty
);
  // way 0 unless it is referenced and way 1 is not
  always_comb begin
    if (!ref_bits[0])      way = 1'b0;
    else if (!ref_bits[1]) way = 1'b1;
    else                   way = 1'b0;
    way_dirty = dirty_bits[way];
  end
endmodule

// File: rtl/nru_cache_ctrl.sv
module nru_cache_ctrl
  import nru_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [ADDR_W-2:0] cpu_blk,
  input  logic              any_hit,
  input  logic              pick_way,
  input  logic              pick_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  input  logic [DATA_W-1:0] vic_w0,
  input  logic [DATA_W-1:0] vic_w1,
  input  logic              mem_ready,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fill_we,
  output logic              fill_sel,
  output logic              install,
  output logic              vic_q
);
  cstate_e state_q;
  logic    beat;

  always_comb begin
    mem_valid = (state_q != ST_IDLE);
    mem_write = (state_q == ST_WB0) || (state_q == ST_WB1);
    beat      = (state_q == ST_WB1) || (state_q == ST_RF1);
    mem_addr  = mem_write ? {vic_tag, cpu_blk[IDX_W-1:0], beat} : {cpu_blk, beat};
    mem_wdata = beat ? vic_w1 : vic_w0;
    cpu_ready = (state_q == ST_IDLE) && cpu_valid && any_hit;
    fill_we   = mem_ready && ((state_q == ST_RF0) || (state_q == ST_RF1));
    fill_sel  = beat;
    install   = mem_ready && (state_q == ST_RF1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vic_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_valid && !any_hit) begin
          vic_q   <= pick_way;
          state_q <= pick_dirty ? ST_WB0 : ST_RF0;
        end
        ST_WB0:  if (mem_ready) state_q <= ST_WB1;
        ST_WB1:  if (mem_ready) state_q <= ST_RF0;
        ST_RF0:  if (mem_ready) state_q <= ST_RF1;
        ST_RF1:  if (mem_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: completion only for a presented request
  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
  // R10: no completion while memory traffic is outstanding
  a_r10_no_ready_during_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready);
  // R11: beat held under back-pressure
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
endmodule

// File: rtl/nru_cache2w.sv
module nru_cache2w
  import nru_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [1:0]        v_w, d_w, r_w, hit;
  logic [TAG_W-1:0]  t_w  [2];
  logic [DATA_W-1:0] w0_w [2];
  logic [DATA_W-1:0] w1_w [2];
  logic              pick_way, pick_dirty, vic_q;
  logic              fill_we, fill_sel, install;

  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr[IDX_W:1];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit[w] = v_w[w] && (t_w[w] == a_tag);
    nru_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (a_idx),
      .ref_set    (cpu_ready && hit[w]),
      .ref_clr    (cpu_ready && hit[1-w]),
      .cpu_we     (cpu_ready && cpu_write && hit[w]),
      .cpu_sel    (cpu_addr[0]),
      .cpu_data   (cpu_wdata),
      .fill_we    (fill_we && (vic_q == 1'(w))),
      .fill_sel   (fill_sel),
      .fill_data  (mem_rdata),
      .install    (install && (vic_q == 1'(w))),
      .install_tag(a_tag),
      .valid_o    (v_w[w]),
      .dirty_o    (d_w[w]),
      .ref_o      (r_w[w]),
      .tag_o      (t_w[w]),
      .w0_o       (w0_w[w]),
      .w1_o       (w1_w[w])
    );
  end

  nru_victim_pick i_pick (
    .ref_bits  (r_w),
    .dirty_bits(d_w & v_w),
    .way       (pick_way),
    .way_dirty (pick_dirty)
  );

  nru_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_blk   (cpu_addr[ADDR_W-1:1]),
    .any_hit   (|hit),
    .pick_way  (pick_way),
    .pick_dirty(pick_dirty),
    .vic_tag   (t_w[vic_q]),
    .vic_w0    (w0_w[vic_q]),
    .vic_w1    (w1_w[vic_q]),
    .mem_ready (mem_ready),
    .cpu_ready (cpu_ready),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fill_we   (fill_we),
    .fill_sel  (fill_sel),
    .install   (install),
    .vic_q     (vic_q)
  );

  always_comb begin
    if (hit[1]) cpu_rdata = cpu_addr[0] ? w1_w[1] : w0_w[1];
    else        cpu_rdata = cpu_addr[0] ? w1_w[0] : w0_w[0];
  end

  // R3: the two ways of the addressed set never both carry R=1
  a_r3_ref_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(r_w) <= 1);
  // R2: a tag is present in at most one way of a set
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/test_nru_cache2w.sv
module test_nru_cache2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nru_cache2w i_nru_cache2w (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem_m [logic [31:0]];
  logic        ev_w [16];
  logic [31:0] ev_a [16];
  logic [31:0] ev_d [16];
  int          ev_n = 0;
  bit          seen = 0;
  logic [31:0] held_a;
  logic        held_w;

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // responder: each beat stalled one cycle, then accepted
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      seen = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (!seen) begin
        seen = 1; held_a = mem_addr; held_w = mem_write;
      end else begin
        chk("R11 held addr", mem_addr, held_a);
        chk("R11 held dir", {31'd0, mem_write}, {31'd0, held_w});
        if (ev_n < 16) begin
          ev_w[ev_n] = mem_write; ev_a[ev_n] = mem_addr; ev_d[ev_n] = mem_write ? mem_wdata : mem_rd(mem_addr);
        end
        ev_n++;
        if (mem_write) mem_m[mem_addr] = mem_wdata;
        mem_rdata = mem_rd(mem_addr);
        mem_ready = 1'b1;
        seen = 0;
      end
    end
  end

  // one processor access; n = negedges waited before ready
  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int n);
    @(negedge clk);
    ev_n = 0;
    cpu_valid = 1'b1; cpu_write = we; cpu_addr = a; cpu_wdata = wd;
    n = 0;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
      n++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic chk_event(string req, int k, logic w, logic [31:0] a, logic [31:0] d);
    chk({req, " dir"}, {31'd0, ev_w[k]}, {31'd0, w});
    chk({req, " addr"}, ev_a[k], a);
    chk({req, " data"}, ev_d[k], d);
  endtask

  task automatic t_reset_and_first_miss();
    logic [31:0] rd; int n;
    chk("R1 ready at reset", {31'd0, cpu_ready}, 32'd0);
    chk("R1 mem_valid at reset", {31'd0, mem_valid}, 32'd0);
    access(1'b0, 32'h0000_0100, '0, rd, n);
    chk("R1 first access misses (beats)", ev_n, 2);
    chk_event("R6 refill beat0", 0, 1'b0, 32'h100, mem_rd(32'h100));
    chk_event("R6 refill beat1", 1, 1'b0, 32'h101, mem_rd(32'h101));
    chk("R10 clean miss stall", n, 6);
    chk("R2 word0 data", rd, mem_rd(32'h100));
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int n;
    access(1'b0, 32'h0000_0101, '0, rd, n);
    chk("R7 hit no beats", ev_n, 0);
    chk("R7 hit same cycle", n, 0);
    chk("R2 word1 select", rd, mem_rd(32'h101));
  endtask

  task automatic t_nru_order();
    logic [31:0] rd; int n;
    access(1'b0, 32'h0000_1100, '0, rd, n);     // B -> way1, clean
    chk("R6 clean victim no write", {31'd0, ev_w[0]}, 32'd0);
    chk("R6 clean miss beats", ev_n, 2);
    access(1'b0, 32'h0000_0100, '0, rd, n);     // A re-referenced
    chk("R3 A still hits", ev_n, 0);
    access(1'b0, 32'h0000_2100, '0, rd, n);     // C evicts B (R=0)
    chk("R4 C miss", ev_n, 2);
    access(1'b0, 32'h0000_0101, '0, rd, n);
    chk("R4 A kept", ev_n, 0);
    chk("R4 A data", rd, mem_rd(32'h101));
    access(1'b0, 32'h0000_1101, '0, rd, n);
    chk("R4 B evicted", ev_n, 2);
    chk("R4 B data", rd, mem_rd(32'h1101));
  endtask

  task automatic t_write_miss_evict();
    logic [31:0] rd; int n;
    access(1'b1, 32'h0000_3003, 32'hDEAD_0001, rd, n);
    chk("R9 write miss beats", ev_n, 2);
    chk_event("R9 refill first", 0, 1'b0, 32'h3002, mem_rd(32'h3002));
    access(1'b0, 32'h0000_3003, '0, rd, n);
    chk("R9 written word", rd, 32'hDEAD_0001);
    access(1'b0, 32'h0000_3002, '0, rd, n);
    chk("R9 other word", rd, mem_rd(32'h3002));
    access(1'b0, 32'h0000_4002, '0, rd, n);     // G -> way1
    access(1'b0, 32'h0000_5002, '0, rd, n);     // H evicts dirty W
    chk("R5 dirty miss beats", ev_n, 4);
    chk("R5 dirty miss stall", n, 12);
    chk_event("R5 wb beat0", 0, 1'b1, 32'h3002, {16'h3002 ^ 16'h5A5A, 16'h3002});
    chk_event("R5 wb beat1", 1, 1'b1, 32'h3003, 32'hDEAD_0001);
    chk_event("R6 refill after wb", 2, 1'b0, 32'h5002, mem_rd(32'h5002));
    chk_event("R6 refill beat1", 3, 1'b0, 32'h5003, mem_rd(32'h5003));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int n;
    access(1'b1, 32'h0000_4003, 32'hBEEF_0002, rd, n);
    chk("R8 write hit no beats", ev_n, 0);
    chk("R8 write hit same cycle", n, 0);
    access(1'b0, 32'h0000_4002, '0, rd, n);
    chk("R8 other word unchanged", rd, mem_rd(32'h4002));
    access(1'b0, 32'h0000_4003, '0, rd, n);
    chk("R8 written word", rd, 32'hBEEF_0002);
    access(1'b0, 32'h0000_5002, '0, rd, n);     // H referenced
    access(1'b0, 32'h0000_6002, '0, rd, n);     // evicts dirty G
    chk("R8 dirty set beats", ev_n, 4);
    chk_event("R8 wb word0", 0, 1'b1, 32'h4002, mem_rd(32'h4002));
    chk_event("R8 wb word1", 1, 1'b1, 32'h4003, 32'hBEEF_0002);
    access(1'b0, 32'h0000_3003, '0, rd, n);     // W comes back from memory
    chk("R5 written-back data", rd, 32'hDEAD_0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_and_first_miss();
    t_read_hit();
    t_nru_order();
    t_write_miss_evict();
    t_write_hit();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule